// File: doc/BRIEF.md
# DMA Address Translation Unit

This block sits between the DMA side of a PCI host bridge and system memory. It turns bus addresses into physical addresses. Software programs two 64-bit registers over a small register bus: a control word and the base address of a translation table. Either register can be accessed as one 64-bit word or as two 32-bit halves.

A client presents a bus address with a valid/ready handshake. When translation is off, the address comes back unchanged with full permission. When translation is on, the block works out which 8-byte table entry covers the address. That choice depends on the granule (8 KB or 64 KB) and on a 3-bit table size code. The block reads that entry through a memory read port and decodes it into three results:
- a physical page address,
- a page offset mask,
- an access right: none, read-only or read-write.

Each response also returns the page-aligned bus address, so the client can join the page base with its own offset bits. Only one request is handled at a time.

Top module: `dma_xlate`

## Requirements
- R1: After reset both registers read as zero, `req_ready` is 1, and neither `mem_req_valid` nor `rsp_valid` is asserted.
- R2: Register offsets behave as follows:
  - 0x0 holds the control register and 0x8 holds the base register.
  - A 64-bit access (`reg_wide`=1) at 0x0 or 0x8 reads or writes the whole register.
  - A 32-bit access at 0x0 or 0x8 reads or writes the upper half. The data travels in bits 31:0 of the bus.
  - Any access at 0x4 or 0xC reads or writes the lower half, in bits 31:0. Reads of a half return zero in bits 63:32.
- R3: Any other offset, including offsets not aligned to 4 bytes, reads as zero. A write there changes neither register.
- R4: With control bit 0 clear, the response comes one cycle after acceptance, and no memory read is made. The response carries:
  - `rsp_paddr` equal to the bus address;
  - `rsp_iova` equal to the address with bits 12:0 cleared;
  - `rsp_mask` equal to 0x1FFF;
  - `rsp_perm` = read-write (2'b11).
- R5: With control bit 0 set and control bit 2 clear (8 KB granule), the entry address is the base plus 8 × ((bus address mod (8 MB << s)) / 8 KB). Here s is control bits 18:16.
- R6: With control bit 2 set (64 KB granule), the entry address is the base plus 8 × ((bus address mod (64 MB << s)) / 64 KB) for s from 0 to 5. Codes 6 and 7 make no memory read and give a no-permission response one cycle after acceptance.
- R7: The entry is big-endian. Byte lane k of `mem_rsp_data` (bits 8k+7:8k) holds the byte at entry address + k, so entry bits 63:56 arrive in lane 0.
- R8: An entry with bit 63 clear gives a response with these fields:
  - `rsp_perm` = none (2'b00);
  - `rsp_paddr` = 0;
  - `rsp_iova` = 0;
  - `rsp_mask` = all ones.
- R9: For a valid entry, bit 1 set gives read-write (2'b11) and bit 1 clear gives read-only (2'b01).
- R10: A valid entry with bit 61 set describes a 64 KB page:
  - `rsp_paddr` = entry bits 40:15, other bits zero;
  - `rsp_mask` = 0xFFFF;
  - `rsp_iova` = bus address with bits 15:0 cleared.
  
  With bit 61 clear the page is 8 KB:
  - `rsp_paddr` = entry bits 40:13;
  - `rsp_mask` = 0x1FFF;
  - `rsp_iova` = bus address with bits 12:0 cleared.
- R11: The request, memory read and response follow this sequence:
  - A request is accepted when `req_valid` and `req_ready` are both high at a clock edge, and `req_ready` then stays low until the response.
  - On a table walk, `mem_req_valid` is high for exactly the one cycle after acceptance.
  - `mem_rsp_valid` is taken only from the cycle after that.
  - `rsp_valid` is high for one cycle, in the cycle after the read data arrives.
  - `req_ready` returns high the cycle after the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for the current offset and width |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block idle, request can be accepted |
| req_addr | input | 64 | Bus address to translate |
| mem_req_valid | output | 1 | Table entry read strobe |
| mem_req_addr | output | 64 | Table entry byte address |
| mem_rsp_valid | input | 1 | Table entry data valid |
| mem_rsp_data | input | 64 | Table entry data, byte lane k = address + k |
| rsp_valid | output | 1 | Translation result valid (one cycle) |
| rsp_iova | output | 64 | Page-aligned bus address |
| rsp_paddr | output | 64 | Physical page address |
| rsp_mask | output | 64 | Page offset mask |
| rsp_perm | output | 2 | 00 none, 01 read-only, 11 read-write |

## Verification
The assertions assume three things about the inputs:
- `mem_rsp_valid` is raised only while a table read is outstanding, at least one cycle after `mem_req_valid`.
- A request is presented only while `req_ready` is high.
- Memory data stays constant for the whole walk.

The stimulus keeps to this:
- Memory responses come from a responder that answers only the strobes it sees, after a programmed delay of one cycle or more.
- Requests are driven only when the block is idle.
- Table entries and register values are changed only between translations.

// File: rtl/dma_xlate_pkg.sv
package dma_xlate_pkg;
  localparam int WORD_W      = 64;
  localparam int HALF_W      = WORD_W / 2;
  localparam int BYTE_W      = 8;
  localparam int LANES       = WORD_W / BYTE_W;
  localparam int ENTRY_LG    = $clog2(LANES);
  localparam int SIZE_W      = 3;
  localparam int CTRL_EN     = 0;
  localparam int CTRL_GRAN   = 2;
  localparam int CTRL_SZ_LSB = 16;
  localparam int SMALL_LG    = 13;
  localparam int BIG_LG      = 16;
  localparam int TBL_MIN_LG  = 10;
  localparam int BIG_MAX_SZ  = 5;
  localparam int ENT_VALID   = 63;
  localparam int ENT_BIG     = 61;
  localparam int ENT_WR      = 1;
  localparam int ENT_PA_MSB  = 40;

  localparam logic [WORD_W-1:0] SMALL_OFS = (WORD_W'(1) << SMALL_LG) - WORD_W'(1);
  localparam logic [WORD_W-1:0] BIG_OFS   = (WORD_W'(1) << BIG_LG) - WORD_W'(1);
  localparam logic [WORD_W-1:0] PA_TOP    = (WORD_W'(1) << (ENT_PA_MSB + 1)) - WORD_W'(1);
  localparam logic [WORD_W-1:0] PA_SMALL  = PA_TOP & ~SMALL_OFS;
  localparam logic [WORD_W-1:0] PA_BIG    = PA_TOP & ~(SMALL_OFS | (WORD_W'(1) << (BIG_LG - 2)) | (WORD_W'(1) << (BIG_LG - 3)));

  typedef enum logic [1:0] {
    PERM_NONE = 2'b00,
    PERM_RO   = 2'b01,
    PERM_RW   = 2'b11
  } perm_e;

  typedef struct packed {
    logic [WORD_W-1:0] iova;
    logic [WORD_W-1:0] paddr;
    logic [WORD_W-1:0] mask;
    perm_e             perm;
  } xlate_res_t;

  function automatic xlate_res_t res_deny();
    xlate_res_t r;
    r.iova  = '0;
    r.paddr = '0;
    r.mask  = '1;
    r.perm  = PERM_NONE;
    return r;
  endfunction

  function automatic xlate_res_t res_pass(input logic [WORD_W-1:0] va);
    xlate_res_t r;
    r.iova  = va & ~SMALL_OFS;
    r.paddr = va;
    r.mask  = SMALL_OFS;
    r.perm  = PERM_RW;
    return r;
  endfunction

  function automatic xlate_res_t res_entry(input logic [WORD_W-1:0] va,
                                           input logic [WORD_W-1:0] ent);
    xlate_res_t r;
    if (!ent[ENT_VALID]) begin
      r = res_deny();
    end else begin
      r.perm = ent[ENT_WR] ? PERM_RW : PERM_RO;
      if (ent[ENT_BIG]) begin
        r.iova  = va & ~BIG_OFS;
        r.paddr = ent & PA_BIG;
        r.mask  = BIG_OFS;
      end else begin
        r.iova  = va & ~SMALL_OFS;
        r.paddr = ent & PA_SMALL;
        r.mask  = SMALL_OFS;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/dma_xlate_regs.sv
module dma_xlate_regs
  import dma_xlate_pkg::*;
#(
  parameter int REG_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic              reg_wide,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic [WORD_W-1:0] ctrl_o,
  output logic [WORD_W-1:0] base_o
);
  localparam int NREG = 2;

  logic [NREG-1:0][WORD_W-1:0] file_q;
  logic [WORD_W-1:0]           upd_val;
  logic [WORD_W-1:0]           cur_val;
  logic                        hit;
  logic                        sel;
  logic                        low_half;
  logic [NREG-1:0]             wr_en;

  assign hit      = (reg_addr[REG_AW-1:4] == '0) && (reg_addr[1:0] == 2'b00);
  assign sel      = reg_addr[3];
  assign low_half = reg_addr[2];
  assign cur_val  = file_q[sel];

  always_comb begin
    upd_val = cur_val;
    if (low_half)      upd_val[HALF_W-1:0]      = reg_wdata[HALF_W-1:0];
    else if (reg_wide) upd_val                  = reg_wdata;
    else               upd_val[WORD_W-1:HALF_W] = reg_wdata[HALF_W-1:0];
  end

  always_comb begin
    if (!hit)          reg_rdata = '0;
    else if (low_half) reg_rdata = {{HALF_W{1'b0}}, cur_val[HALF_W-1:0]};
    else if (reg_wide) reg_rdata = cur_val;
    else               reg_rdata = {{HALF_W{1'b0}}, cur_val[WORD_W-1:HALF_W]};
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    assign wr_en[g] = reg_valid && reg_write && hit && (sel == g[0]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        file_q[g] <= '0;
      else if (wr_en[g]) file_q[g] <= upd_val;
    end
  end

  assign ctrl_o = file_q[0];
  assign base_o = file_q[1];
endmodule

// File: rtl/dma_xlate_index.sv
module dma_xlate_index
  import dma_xlate_pkg::*;
(
  input  logic              big_gran,
  input  logic [SIZE_W-1:0] size_code,
  input  logic [WORD_W-1:0] base,
  input  logic [WORD_W-1:0] va,
  output logic [WORD_W-1:0] ent_addr,
  output logic              size_ok
);
  localparam int SMALL_MSB = SMALL_LG + TBL_MIN_LG - 1;
  localparam int BIG_MSB   = BIG_LG + TBL_MIN_LG - 1;

  int                hi;
  int                lo;
  int                sh;
  logic [WORD_W-1:0] fmask;

  always_comb begin
    if (big_gran) begin
      lo = BIG_LG;
      hi = BIG_MSB + int'(size_code);
    end else begin
      lo = SMALL_LG;
      hi = SMALL_MSB + int'(size_code);
    end
    sh       = lo - ENTRY_LG;
    fmask    = ({WORD_W{1'b1}} >> (WORD_W - 1 - hi)) & ({WORD_W{1'b1}} << lo);
    ent_addr = base + ((va & fmask) >> sh);
    size_ok  = !big_gran || (size_code <= SIZE_W'(BIG_MAX_SZ));
  end
endmodule

// File: rtl/dma_xlate_swap.sv
module dma_xlate_swap
  import dma_xlate_pkg::*;
(
  input  logic [WORD_W-1:0] lanes_in,
  output logic [WORD_W-1:0] word_out
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign word_out[(LANES-1-k)*BYTE_W +: BYTE_W] = lanes_in[k*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/dma_xlate_seq.sv
module dma_xlate_seq
  import dma_xlate_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xl_en,
  input  logic              size_ok,
  input  logic [WORD_W-1:0] ent_addr,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [WORD_W-1:0] req_addr,
  output logic              mem_req_valid,
  output logic [WORD_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [WORD_W-1:0] entry,
  output logic              rsp_valid,
  output xlate_res_t        rsp
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_RESP} state_e;

  state_e            state_q, state_d;
  logic [WORD_W-1:0] va_q, ma_q;
  xlate_res_t        res_q, res_d;
  logic              take_req, load_res;

  assign take_req = (state_q == S_IDLE) && req_valid;

  always_comb begin
    state_d  = state_q;
    res_d    = res_q;
    load_res = 1'b0;
    case (state_q)
      S_IDLE: if (req_valid) begin
        load_res = 1'b1;
        if (!xl_en) begin
          res_d   = res_pass(req_addr);
          state_d = S_RESP;
        end else if (!size_ok) begin
          res_d   = res_deny();
          state_d = S_RESP;
        end else begin
          state_d = S_ISSUE;
        end
      end
      S_ISSUE: state_d = S_WAIT;
      S_WAIT: if (mem_rsp_valid) begin
        load_res = 1'b1;
        res_d    = res_entry(va_q, entry);
        state_d  = S_RESP;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      va_q    <= '0;
      ma_q    <= '0;
      res_q   <= res_deny();
    end else begin
      state_q <= state_d;
      if (take_req) begin
        va_q <= req_addr;
        ma_q <= ent_addr;
      end
      if (load_res) res_q <= res_d;
    end
  end

  assign req_ready     = (state_q == S_IDLE);
  assign mem_req_valid = (state_q == S_ISSUE);
  assign mem_req_addr  = ma_q;
  assign rsp_valid     = (state_q == S_RESP);
  assign rsp           = res_q;
endmodule

// File: rtl/dma_xlate.sv
module dma_xlate
  import dma_xlate_pkg::*;
#(
  parameter int REG_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic              reg_wide,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [63:0]       reg_wdata,
  output logic [63:0]       reg_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [63:0]       req_addr,
  output logic              mem_req_valid,
  output logic [63:0]       mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [63:0]       mem_rsp_data,
  output logic              rsp_valid,
  output logic [63:0]       rsp_iova,
  output logic [63:0]       rsp_paddr,
  output logic [63:0]       rsp_mask,
  output logic [1:0]        rsp_perm
);
  logic [WORD_W-1:0] ctrl_q, base_q, ent_addr, entry;
  logic              size_ok;
  xlate_res_t        rsp;

  dma_xlate_regs #(.REG_AW(REG_AW)) regs_i (
    .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_wide(reg_wide), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ctrl_o(ctrl_q), .base_o(base_q)
  );

  dma_xlate_index index_i (
    .big_gran(ctrl_q[CTRL_GRAN]),
    .size_code(ctrl_q[CTRL_SZ_LSB +: SIZE_W]),
    .base(base_q), .va(req_addr), .ent_addr(ent_addr), .size_ok(size_ok)
  );

  dma_xlate_swap swap_i (.lanes_in(mem_rsp_data), .word_out(entry));

  dma_xlate_seq seq_i (
    .clk(clk), .rst_n(rst_n), .xl_en(ctrl_q[CTRL_EN]), .size_ok(size_ok),
    .ent_addr(ent_addr), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .mem_req_valid(mem_req_valid),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .entry(entry), .rsp_valid(rsp_valid), .rsp(rsp)
  );

  assign rsp_iova  = rsp.iova;
  assign rsp_paddr = rsp.paddr;
  assign rsp_mask  = rsp.mask;
  assign rsp_perm  = rsp.perm;
endmodule

// File: rtl/dma_xlate_chk.sv
module dma_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        mem_req_valid,
  input logic        rsp_valid,
  input logic [1:0]  rsp_perm,
  input logic [63:0] rsp_paddr,
  input logic [63:0] rsp_iova,
  input logic        xl_en,
  input logic        big_gran,
  input logic [2:0]  size_code
);
  // R11
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  // R11
  single_mem_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> (!mem_req_valid && !rsp_valid));
  // R11
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));
  // R4
  pass_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !xl_en) |=> (rsp_valid && rsp_perm == 2'b11));
  // R6
  bad_size_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && xl_en && big_gran && size_code > 3'd5)
      |=> (rsp_valid && rsp_perm == 2'b00 && !mem_req_valid));
  // R8
  deny_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_perm == 2'b00) |-> (rsp_paddr == 64'd0 && rsp_iova == 64'd0));
endmodule

bind dma_xlate dma_xlate_chk chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .mem_req_valid(mem_req_valid), .rsp_valid(rsp_valid), .rsp_perm(rsp_perm),
  .rsp_paddr(rsp_paddr), .rsp_iova(rsp_iova), .xl_en(ctrl_q[0]),
  .big_gran(ctrl_q[2]), .size_code(ctrl_q[18:16])
);

// File: tb/dma_xlate_tb.sv
module dma_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_valid, reg_write, reg_wide;
  logic [7:0]  reg_addr;
  logic [63:0] reg_wdata, reg_rdata;
  logic        req_valid, req_ready;
  logic [63:0] req_addr;
  logic        mem_req_valid;
  logic [63:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [63:0] mem_rsp_data;
  logic        rsp_valid;
  logic [63:0] rsp_iova, rsp_paddr, rsp_mask;
  logic [1:0]  rsp_perm;

  always #5 clk = ~clk;

  dma_xlate dut_i (
    .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_wide(reg_wide), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .mem_req_valid(mem_req_valid),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .rsp_valid(rsp_valid), .rsp_iova(rsp_iova),
    .rsp_paddr(rsp_paddr), .rsp_mask(rsp_mask), .rsp_perm(rsp_perm)
  );

  int total = 0;
  int bad = 0;

  task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural memory image of table entries (logical 64-bit values)
  logic [63:0] tbl [logic [63:0]];
  int          mem_delay = 1;

  function automatic logic [63:0] tbl_get(input logic [63:0] a);
    if (tbl.exists(a)) return tbl[a];
    return 64'd0;
  endfunction

  function automatic logic [63:0] to_lanes(input logic [63:0] v);
    logic [63:0] r;
    for (int k = 0; k < 8; k++) r[k*8 +: 8] = v[63 - k*8 -: 8];
    return r;
  endfunction

  // memory responder
  int        wait_cnt = 0;
  logic [63:0] pend_addr;
  always @(negedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid) begin
      pend_addr = mem_req_addr;
      wait_cnt  = mem_delay;
    end else if (wait_cnt > 0) begin
      wait_cnt--;
      if (wait_cnt == 0) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= to_lanes(tbl_get(pend_addr));
      end
    end
  end

  // reference model state
  logic [63:0]    m_ctrl, m_base;
  int             phase;
  logic [63:0]    e_maddr, e_iova, e_paddr, e_mask;
  logic [1:0]     e_perm;
  string          e_tag, e_atag;

  function automatic logic [63:0] m_read(input logic [7:0] a, input logic w);
    logic [63:0] r;
    if (a >= 8'd16 || (a % 4) != 0) return 64'd0;
    r = (a >= 8'd8) ? m_base : m_ctrl;
    if ((a % 8) == 4) return {32'd0, r[31:0]};
    if (w) return r;
    return {32'd0, r[63:32]};
  endfunction

  task automatic m_accept(input logic [63:0] va);
    longint unsigned region, pg, idx;
    logic [63:0] ent;
    int s;
    s = int'(m_ctrl[18:16]);
    if (!m_ctrl[0]) begin
      e_tag = "R4"; e_iova = va & ~64'h1FFF; e_paddr = va;
      e_mask = 64'h1FFF; e_perm = 2'b11; phase = 3;
      return;
    end
    if (m_ctrl[2]) begin
      if (s > 5) begin
        e_tag = "R6"; e_iova = 0; e_paddr = 0; e_mask = '1; e_perm = 2'b00;
        phase = 3;
        return;
      end
      region = 64'd67108864 << s; pg = 65536; e_atag = "R6";
    end else begin
      region = 64'd8388608 << s; pg = 8192; e_atag = "R5";
    end
    idx = (va % region) / pg;
    e_maddr = m_base + idx * 8;
    ent = tbl_get(e_maddr);
    phase = 1;
    if (!ent[63]) begin
      e_tag = "R7/R8"; e_iova = 0; e_paddr = 0; e_mask = '1; e_perm = 2'b00;
    end else begin
      e_perm = ent[1] ? 2'b11 : 2'b01;
      if (ent[61]) begin
        e_tag = "R7/R9/R10"; e_iova = va & ~64'hFFFF;
        e_paddr = ent & 64'h1FFFFFF8000; e_mask = 64'hFFFF;
      end else begin
        e_tag = "R7/R9/R10"; e_iova = va & ~64'h1FFF;
        e_paddr = ent & 64'h1FFFFFFE000; e_mask = 64'h1FFF;
      end
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase = 0; m_ctrl = 0; m_base = 0;
    end else begin
      case (phase)
        0: if (req_valid) m_accept(req_addr);
        1: phase = 2;
        2: if (mem_rsp_valid) phase = 3;
        default: phase = 0;
      endcase
      if (reg_valid && reg_write && reg_addr < 8'd16 && (reg_addr % 4) == 0) begin
        logic [63:0] v;
        v = (reg_addr >= 8'd8) ? m_base : m_ctrl;
        if ((reg_addr % 8) == 4) v[31:0] = reg_wdata[31:0];
        else if (reg_wide) v = reg_wdata;
        else v[63:32] = reg_wdata[31:0];
        if (reg_addr >= 8'd8) m_base = v; else m_ctrl = v;
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    check64("R11 req_ready", 64'(req_ready), 64'(phase == 0));
    check64("R11 mem_req_valid", 64'(mem_req_valid), 64'(phase == 1));
    check64("R11 rsp_valid", 64'(rsp_valid), 64'(phase == 3));
    check64((reg_addr < 8'd16 && reg_addr % 4 == 0) ? "R2 reg_rdata" : "R3 reg_rdata",
            reg_rdata, m_read(reg_addr, reg_wide));
    if (phase == 1) check64({e_atag, " mem_req_addr"}, mem_req_addr, e_maddr);
    if (phase == 3) begin
      check64({e_tag, " rsp_iova"}, rsp_iova, e_iova);
      check64({e_tag, " rsp_paddr"}, rsp_paddr, e_paddr);
      check64({e_tag, " rsp_mask"}, rsp_mask, e_mask);
      check64({e_tag, " rsp_perm"}, 64'(rsp_perm), 64'(e_perm));
    end
  end

  task automatic wr(input logic [7:0] a, input logic w, input logic [63:0] d);
    @(negedge clk); #1;
    reg_valid = 1; reg_write = 1; reg_addr = a; reg_wide = w; reg_wdata = d;
    @(negedge clk); #1;
    reg_valid = 0; reg_write = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic w);
    @(negedge clk); #1;
    reg_addr = a; reg_wide = w;
    @(negedge clk);
  endtask

  task automatic xl(input logic [63:0] va, input int dly);
    mem_delay = dly;
    @(negedge clk); #1;
    req_valid = 1; req_addr = va;
    @(negedge clk); #1;
    req_valid = 0;
    while (!rsp_valid) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [63:0] e8(input logic [63:0] b, input logic [63:0] va, input int s);
    return b + ((va % (64'd8388608 << s)) / 8192) * 8;
  endfunction
  function automatic logic [63:0] e64(input logic [63:0] b, input logic [63:0] va, input int s);
    return b + ((va % (64'd67108864 << s)) / 65536) * 8;
  endfunction

  initial begin
    rst_n = 0; reg_valid = 0; reg_write = 0; reg_wide = 1; reg_addr = 0;
    reg_wdata = 0; req_valid = 0; req_addr = 0; mem_rsp_valid = 0; mem_rsp_data = 0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    // R1 reset state
    rd(8'h00, 1); check64("R1 ctrl reset", reg_rdata, 64'd0);
    check64("R1 ready reset", 64'(req_ready), 64'd1);
    rd(8'h08, 1); check64("R1 base reset", reg_rdata, 64'd0);
    // R2 register halves
    wr(8'h08, 1, 64'h1122_3344_5566_7788);
    rd(8'h08, 0); check64("R2 upper half", reg_rdata, 64'h1122_3344);
    rd(8'h0C, 0); check64("R2 lower half", reg_rdata, 64'h5566_7788);
    wr(8'h08, 0, 64'hFFFF_FFFF_0000_00AB);
    wr(8'h0C, 1, 64'hFFFF_FFFF_0040_0000);
    rd(8'h08, 1); check64("R2 split write", reg_rdata, 64'h0000_00AB_0040_0000);
    // R3 ignored offsets
    wr(8'h10, 1, '1); wr(8'h02, 1, '1); wr(8'h40, 0, '1);
    rd(8'h08, 1); check64("R3 base untouched", reg_rdata, 64'h0000_00AB_0040_0000);
    rd(8'h00, 1); check64("R3 ctrl untouched", reg_rdata, 64'd0);
    rd(8'h10, 1); check64("R3 hole reads zero", reg_rdata, 64'd0);
    // R4 passthrough
    xl(64'h0000_1234_5678_9ABC, 1);
    xl(64'hFFFF_FFFF_FFFF_FFFF, 1);
    // R5 8K granule, several sizes
    wr(8'h08, 1, 64'h0000_0000_0010_0000);
    for (int s = 0; s < 8; s++) begin
      logic [63:0] va;
      va = 64'h0000_00F7_ABCD_E123 + 64'(s) * 64'h0123_4567;
      tbl[e8(64'h10_0000, va, s)] = (s % 2 == 0) ?
        64'h8000_0123_4567_A002 : 64'hA000_00FE_DCBA_F000;
      wr(8'h04, 0, 64'(s) << 16 | 64'h1);
      xl(va, 1 + s % 3);
    end
    // R8 invalid entry (R9 read-only covered above)
    wr(8'h04, 0, 64'h1);
    xl(64'h0000_0000_0055_0000, 2);
    tbl[e8(64'h10_0000, 64'h66_4000, 0)] = 64'h7FFF_FFFF_FFFF_FFFF;
    xl(64'h0000_0000_0066_4000, 1);
    // R6 64K granule
    for (int s = 0; s < 8; s++) begin
      logic [63:0] va;
      va = 64'h0000_0003_FEDC_BA98 + 64'(s) * 64'h0765_4321;
      tbl[e64(64'h10_0000, va, s)] = (s % 2 == 0) ?
        64'hA000_0000_1234_8002 : 64'h8000_01FF_FFFF_FFFD;
      wr(8'h04, 0, 64'(s) << 16 | 64'h5);
      xl(va, 1 + s % 2);
    end
    // R11 back-to-back with slow memory
    wr(8'h04, 0, 64'h1);
    xl(64'h0000_0000_0000_2000, 5);
    xl(64'h0000_0000_0000_2000, 1);
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule